// File: doc/BRIEF.md
# ADC Parallel Sample Capture

This block sits directly behind the receive pads of a 12-bit pipelined converter. The converter drives a source-synchronous parallel bus, and the block runs in the converter's data clock domain. Two lane modes are supported. In single data rate mode, twelve lanes carry a whole sample and are taken on the rising edge. In double data rate mode, six lanes carry the upper half of a sample on the rising edge and the lower half on the falling edge. The block rebuilds each sample as a 12-bit word and presents it with a one-cycle valid strobe.

The converter produces offset binary code. The block passes that code through unchanged or converts it to two's complement. The converter also sends an out-of-range bit with each sample, and the block splits it into an over-range-high flag and an under-range-low flag. It decides between them with the sample's most significant bit, taken before any format conversion.

The lane mode is loaded only while capture is disabled or the block is in reset. Disabling capture throws away any sample of which only one half has arrived.

Top module: `adc_capture`

## Requirements
- R1: While reset is asserted, the sample valid strobe, both range flags and the sample output are all zero, and the lane mode is single data rate.
- R2: In single data rate mode with capture enabled, the 12 lanes taken at a rising edge appear on the sample output, with valid high, right after that same edge, which is one register stage.
- R3: In double data rate mode, lanes [5:0] taken at a rising edge become sample bits [11:6] and lanes [5:0] taken at the next falling edge become bits [5:0]. The joined word is issued at the following rising edge. Lanes [11:6] have no effect in this mode.
- R4: With the format select low, the offset binary code is output unchanged. With it high, the code is output with bit 11 inverted, which gives two's complement. The select and the range bit are taken with the rising edge that carries bit 11.
- R5: The over-range-high flag is set with a sample exactly when that sample's range bit is 1 and its unconverted bit 11 is 1.
- R6: The under-range-low flag is set with a sample exactly when that sample's range bit is 1 and its unconverted bit 11 is 0. Both flags are 0 when the range bit is 0.
- R7: Valid is high for exactly one cycle per sample and is never high in a cycle that follows a rising edge at which capture was disabled. Both flags are 0 whenever valid is 0.
- R8: The mode select is loaded only at rising edges where capture is disabled. A change while capture is enabled has no effect on the lane mode in use.
- R9: Disabling capture in double data rate mode discards a half-received sample. After capture is re-enabled, the first valid word carries only halves taken after re-enabling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter data clock, running at the sample rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_en | input | 1 | Capture enable. When low, the block is idle and loads the mode select |
| ddr_mode_i | input | 1 | Lane mode select: 0 for single data rate, 1 for double data rate |
| twos_fmt_i | input | 1 | Output format: 0 for offset binary, 1 for two's complement |
| lanes_i | input | 12 | Parallel data lanes from the converter |
| oor_i | input | 1 | Out-of-range bit from the converter |
| sample_o | output | 12 | Rebuilt sample word |
| sample_valid_o | output | 1 | One-cycle strobe marking a new sample |
| over_hi_o | output | 1 | Sample beyond positive full scale |
| under_lo_o | output | 1 | Sample beyond negative full scale |

## Verification
The hardest case to reach is a double data rate sample that is cut off after its first half, when capture is dropped between the falling edge and the next rising edge. That stale half then has to be shown never to reach the output. The stimulus drives lanes on both clock phases, enables capture for one rising edge, drops it before the pairing edge, and re-enables it. It then checks that no valid strobe appears until a completely new pair has arrived. A mode select that toggles while capture is enabled is driven with full-width single data rate data, so a mode switch taken by mistake would show up as a wrong word.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

  localparam int unsigned DEFAULT_SAMPLE_W = 12;

  typedef enum logic {
    MODE_SDR = 1'b0,
    MODE_DDR = 1'b1
  } cap_mode_e;

endpackage

// File: rtl/adc_lane_deser.sv
module adc_lane_deser
  import adc_cap_pkg::*;
#(
  parameter int unsigned SAMPLE_W = DEFAULT_SAMPLE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cap_en,
  input  logic                ddr_mode_i,
  input  logic                twos_fmt_i,
  input  logic                oor_i,
  input  logic [SAMPLE_W-1:0] lanes_i,
  output cap_mode_e           mode_o,
  output logic                word_vld_o,
  output logic [SAMPLE_W-1:0] word_o,
  output logic                word_oor_o,
  output logic                word_twos_o
);

  localparam int unsigned HALF_W = SAMPLE_W / 2;

  cap_mode_e           mode_q;
  logic [HALF_W-1:0]   upper_q;
  logic [HALF_W-1:0]   lower_q;
  logic                oor_q;
  logic                twos_q;
  logic                half_pend_q;

  // named events for checking
  logic                ddr_emit;
  logic                sdr_take;
  logic                ddr_active;

  assign ddr_active = cap_en && (mode_q == MODE_DDR);
  assign ddr_emit   = ddr_active && half_pend_q;
  assign sdr_take   = cap_en && (mode_q == MODE_SDR);

  // mode register: loaded only while idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_SDR;
    end else if (!cap_en) begin
      mode_q <= cap_mode_e'(ddr_mode_i);
    end
  end

  // rising edge half (upper bits, range bit, format select)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q     <= '0;
      oor_q       <= 1'b0;
      twos_q      <= 1'b0;
      half_pend_q <= 1'b0;
    end else if (!ddr_active) begin
      half_pend_q <= 1'b0;
    end else begin
      upper_q     <= lanes_i[HALF_W-1:0];
      oor_q       <= oor_i;
      twos_q      <= twos_fmt_i;
      half_pend_q <= 1'b1;
    end
  end

  // falling edge half (lower bits)
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lower_q <= '0;
    end else if (ddr_active) begin
      lower_q <= lanes_i[HALF_W-1:0];
    end
  end

  always_comb begin
    if (mode_q == MODE_DDR) begin
      word_vld_o  = ddr_emit;
      word_o      = {upper_q, lower_q};
      word_oor_o  = oor_q;
      word_twos_o = twos_q;
    end else begin
      word_vld_o  = sdr_take;
      word_o      = lanes_i;
      word_oor_o  = oor_i;
      word_twos_o = twos_fmt_i;
    end
  end

  assign mode_o = mode_q;

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && $past(cap_en)) |-> $stable(mode_q));

  // R9
  ddr_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ddr_emit |-> ($past(cap_en) && $past(mode_q) == MODE_DDR));

endmodule

// File: rtl/adc_code_fmt.sv
module adc_code_fmt #(
  parameter int unsigned SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                word_vld_i,
  input  logic [SAMPLE_W-1:0] word_i,
  input  logic                word_oor_i,
  input  logic                word_twos_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                sample_valid_o,
  output logic                over_hi_o,
  output logic                under_lo_o
);

  localparam int unsigned MSB = SAMPLE_W - 1;

  function automatic logic [SAMPLE_W-1:0] recode(input logic [SAMPLE_W-1:0] code,
                                                 input logic twos);
    logic [SAMPLE_W-1:0] r;
    r = code;
    if (twos) r[MSB] = ~code[MSB];
    return r;
  endfunction

  function automatic logic range_high(input logic [SAMPLE_W-1:0] code, input logic oor);
    return oor && code[MSB];
  endfunction

  function automatic logic range_low(input logic [SAMPLE_W-1:0] code, input logic oor);
    return oor && !code[MSB];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_o       <= '0;
      sample_valid_o <= 1'b0;
      over_hi_o      <= 1'b0;
      under_lo_o     <= 1'b0;
    end else begin
      sample_valid_o <= word_vld_i;
      if (word_vld_i) begin
        sample_o   <= recode(word_i, word_twos_i);
        over_hi_o  <= range_high(word_i, word_oor_i);
        under_lo_o <= range_low(word_i, word_oor_i);
      end else begin
        over_hi_o  <= 1'b0;
        under_lo_o <= 1'b0;
      end
    end
  end

  // R5 R6
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(over_hi_o && under_lo_o));

  // R7
  flag_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (over_hi_o || under_lo_o) |-> sample_valid_o);

endmodule

// File: rtl/adc_capture.sv
module adc_capture
  import adc_cap_pkg::*;
#(
  parameter int unsigned SAMPLE_W = DEFAULT_SAMPLE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cap_en,
  input  logic                ddr_mode_i,
  input  logic                twos_fmt_i,
  input  logic [SAMPLE_W-1:0] lanes_i,
  input  logic                oor_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                sample_valid_o,
  output logic                over_hi_o,
  output logic                under_lo_o
);

  cap_mode_e           lane_mode;
  logic                word_vld;
  logic [SAMPLE_W-1:0] word;
  logic                word_oor;
  logic                word_twos;

  adc_lane_deser #(.SAMPLE_W(SAMPLE_W)) u_deser (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap_en      (cap_en),
    .ddr_mode_i  (ddr_mode_i),
    .twos_fmt_i  (twos_fmt_i),
    .oor_i       (oor_i),
    .lanes_i     (lanes_i),
    .mode_o      (lane_mode),
    .word_vld_o  (word_vld),
    .word_o      (word),
    .word_oor_o  (word_oor),
    .word_twos_o (word_twos)
  );

  adc_code_fmt #(.SAMPLE_W(SAMPLE_W)) u_fmt (
    .clk            (clk),
    .rst_n          (rst_n),
    .word_vld_i     (word_vld),
    .word_i         (word),
    .word_oor_i     (word_oor),
    .word_twos_i    (word_twos),
    .sample_o       (sample_o),
    .sample_valid_o (sample_valid_o),
    .over_hi_o      (over_hi_o),
    .under_lo_o     (under_lo_o)
  );

  // R2
  sdr_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && lane_mode == MODE_SDR) |=> sample_valid_o);

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> !sample_valid_o);

endmodule

// File: tb/tb_adc_capture.sv
module tb_adc_capture;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {twos, oor, word}
  localparam logic [13:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 12'hFFF},
    {1'b0, 1'b1, 12'h000},
    {1'b1, 1'b0, 12'h800},
    {1'b1, 1'b0, 12'h7FF},
    {1'b1, 1'b1, 12'hFFF},
    {1'b1, 1'b1, 12'h000},
    {1'b0, 1'b0, 12'h5A3},
    {1'b1, 1'b0, 12'h3C6}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_en = 1'b0;
  logic        ddr_mode = 1'b0;
  logic        twos = 1'b0;
  logic [11:0] lanes = '0;
  logic        oor = 1'b0;
  logic [11:0] sample;
  logic        valid, over_hi, under_lo;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_capture dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .cap_en         (cap_en),
    .ddr_mode_i     (ddr_mode),
    .twos_fmt_i     (twos),
    .lanes_i        (lanes),
    .oor_i          (oor),
    .sample_o       (sample),
    .sample_valid_o (valid),
    .over_hi_o      (over_hi),
    .under_lo_o     (under_lo)
  );

  function automatic logic [14:0] model(input logic [13:0] v);
    int s;
    logic [11:0] w;
    w = v[11:0];
    s = v[13] ? int'(w) - 2048 : int'(w);
    return {1'b1, v[12] && (w >= 12'd2048), v[12] && (w < 12'd2048), s[11:0]};
  endfunction

  function automatic logic [14:0] obs();
    return {valid, over_hi, under_lo, sample};
  endfunction

  task automatic chk(input string req, input logic [14:0] act, input logic [14:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sdr_send(input logic [13:0] v);
    @(negedge clk);
    #1;
    lanes = v[11:0]; oor = v[12]; twos = v[13];
    @(posedge clk);
    #2;
  endtask

  task automatic ddr_send(input logic [13:0] v);
    @(negedge clk);
    #2;
    lanes = {6'h2A, v[11:6]}; oor = v[12]; twos = v[13];
    @(posedge clk);
    #2;
    lanes = {6'h15, v[5:0]};
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [13:0] y;
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    chk("R1 reset outputs", obs(), 15'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    cap_en = 1'b1;

    // R2 R4 R5 R6: single data rate table
    for (int i = 0; i < NVEC; i++) begin
      sdr_send(VEC[i]);
      chk("R2/R4/R5/R6 sdr vector", obs(), model(VEC[i]));
    end

    // R8: mode change while enabled is ignored
    @(negedge clk);
    ddr_mode = 1'b1;
    sdr_send({1'b0, 1'b0, 12'hABC});
    chk("R8 mode held while enabled", obs(), model({1'b0, 1'b0, 12'hABC}));

    // R7: drop capture, valid and flags must fall
    sdr_send({1'b0, 1'b1, 12'hFFF});
    chk("R5 sdr over range", obs(), model({1'b0, 1'b1, 12'hFFF}));
    @(negedge clk);
    cap_en = 1'b0;
    @(posedge clk);
    #2;
    chk("R7 no valid when idle", {12'h0, valid, over_hi, under_lo}, 15'h0);

    // switch to double data rate while idle (mode already loaded from ddr_mode=1)
    cap_en = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      ddr_send(VEC[i]);
      if (i == 0) chk("R3 first half gives no valid", {14'h0, valid}, 15'h0);
      else        chk("R3/R4/R5/R6 ddr vector", obs(), model(VEC[i-1]));
    end
    ddr_send(14'h0);
    chk("R3 ddr last vector", obs(), model(VEC[NVEC-1]));

    // R9: half-received sample discarded on idle
    @(negedge clk);
    #2;
    cap_en = 1'b0;
    @(posedge clk);
    #2;
    chk("R9 idle suppresses pending half", {14'h0, valid}, 15'h0);
    cap_en = 1'b1;
    y = {1'b0, 1'b1, 12'h9E1};
    ddr_send(y);
    chk("R9 stale half not issued", {14'h0, valid}, 15'h0);
    ddr_send(14'h0);
    chk("R9 fresh pair after re-enable", obs(), model(y));
    ddr_send({1'b1, 1'b1, 12'h0F0});
    chk("R7 single strobe per sample", {14'h0, valid}, 15'h1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule